// File: doc/BRIEF.md
# Timer Input Capture Unit

The block timestamps transitions on an already-synchronized capture pin. When a transition qualifies under the selected mode, the block copies the current count of a free-running timer into a small capture FIFO. The timer can be one of two 16-bit count buses, or both buses joined as a 32-bit value. Software reads the stored timestamps through a valid/ready read stream. A one-cycle interrupt pulse fires after a programmable number of stored captures.

A single 32-bit control register holds the configuration: enable, debug freeze, idle stop, first-edge select, wide capture, timer select, interrupt rate and capture mode. Two read-only status bits sit in the same register: overflow and data-available. Debug and idle status inputs can suspend capture. Popping from the FIFO is still allowed while capture is suspended.

Read stream rules: `rd_valid` is high whenever the FIFO holds data, and `rd_data` then shows the oldest entry. A pop happens on a clock edge where both `rd_valid` and `rd_ready` are high. While `rd_ready` is low, `rd_valid` stays high and `rd_data` does not change. Capture never waits for the reader. A capture that finds the FIFO full and no pop in the same cycle is dropped. A capture in a cycle that also pops is stored.

Top module: `tcap_unit`

## Requirements
- R1: Control register bits 31:16 and 12:10 always read 0, and writes to them have no effect. The writable fields read back at their positions: 15 enable, 13 idle stop, 9 first edge, 8 wide, 7 timer select, 6:5 interrupt rate, 2:0 mode.
- R2: While enable (bit 15) is 0, no capture is stored and no interrupt pulse occurs. Within one cycle the FIFO is emptied, `rd_valid` drops, and overflow (bit 4) and data-available (bit 3) read 0.
- R3: Freeze (bit 14) accepts a write only while `dbg_mode` is 1, and it reads 1 only when it is set and `dbg_mode` is 1. While it is set and `dbg_mode` is 1, capture is suspended.
- R4: While idle stop (bit 13) is 1 and `cpu_idle` is 1, capture is suspended. With bit 13 at 0, `cpu_idle` has no effect.
- R5: Mode 3'b001 captures every edge, 3'b010 every falling edge, and 3'b011 every rising edge. Modes 3'b000 and 3'b111 capture nothing.
- R6: Mode 3'b100 captures on every 4th rising edge, and mode 3'b101 captures on every 16th rising edge.
- R7: In mode 3'b110 the first capture takes the polarity given by bit 9 (1 = rising, 0 = falling). Edges of the other polarity are skipped until that capture. After it, the captured polarity alternates.
- R8: With bit 8 at 1, the stored value is {`tmr_b`, `tmr_a`}. With bit 8 at 0, the stored value is `tmr_a` if bit 7 is 1, or `tmr_b` if bit 7 is 0, zero-extended. Bit 7 has no effect when bit 8 is 1.
- R9: `irq` pulses for one cycle on the 1st, 2nd, 3rd or 4th stored capture since the last pulse, for rate field values 0, 1, 2 and 3. Dropped captures are not counted.
- R10: The FIFO holds 4 entries, and bit 3 reads 1 while it holds data. A capture into a full FIFO with no pop is discarded and sets bit 4. Any pop clears bit 4.
- R11: A control write clears the interrupt count and the prescale count, reloads the alternate-mode polarity from bit 9, and blocks any capture in the same cycle.
- R12: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` stays 1 and `rd_data` holds its value on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read value with status bits |
| dbg_mode | input | 1 | Debug mode active |
| cpu_idle | input | 1 | Processor idle |
| tmr_a | input | 16 | Timer A count |
| tmr_b | input | 16 | Timer B count (upper half in wide mode) |
| cap_pin | input | 1 | Synchronized capture input |
| rd_valid | output | 1 | FIFO holds a timestamp |
| rd_ready | input | 1 | Reader accepts the timestamp |
| rd_data | output | 32 | Oldest timestamp |
| irq | output | 1 | Capture interrupt pulse |

## Verification
A wrong prescale count or a wrong alternate-polarity state shows up as a missing or extra FIFO entry, or a wrong stored timer value, one cycle after the qualifying edge. The reference model catches this on the very next clock. A corrupted interrupt count shows up as an `irq` pulse on the wrong stored capture. FIFO pointer or overflow errors show up as wrong data on the read stream or a wrong status bit, at the first pop or overflow after the fault.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  typedef enum logic [2:0] {
    CM_OFF    = 3'b000,
    CM_ANY    = 3'b001,
    CM_FALL   = 3'b010,
    CM_RISE   = 3'b011,
    CM_RISE4  = 3'b100,
    CM_RISE16 = 3'b101,
    CM_ALT    = 3'b110,
    CM_RSVD   = 3'b111
  } cap_mode_e;

  typedef struct packed {
    logic      en;
    logic      frz;
    logic      sidl;
    logic      fedge;
    logic      wide;
    logic      sel_a;
    logic [1:0] irate;
    cap_mode_e mode;
  } cap_cfg_t;

  localparam int unsigned POS_EN    = 15;
  localparam int unsigned POS_FRZ   = 14;
  localparam int unsigned POS_SIDL  = 13;
  localparam int unsigned POS_FEDGE = 9;
  localparam int unsigned POS_WIDE  = 8;
  localparam int unsigned POS_SEL   = 7;
  localparam int unsigned POS_RATE  = 5;
  localparam int unsigned POS_OVF   = 4;
  localparam int unsigned POS_NE    = 3;

endpackage

// File: rtl/tcap_edge.sv
module tcap_edge
  import tcap_pkg::*;
#(
  parameter int unsigned PRE_SHORT = 4,
  parameter int unsigned PRE_LONG  = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      run,
  input  logic      alt_init,
  input  logic      pin,
  input  cap_mode_e mode,
  output logic      evt
);
  localparam int unsigned PW = $clog2(PRE_LONG);
  localparam logic [PW-1:0] LIM_S = PW'(PRE_SHORT - 1);
  localparam logic [PW-1:0] LIM_L = PW'(PRE_LONG - 1);

  logic          pin_q;
  logic          rise, fall;
  logic [PW-1:0] pre_q, pre_d, lim;
  logic          alt_q, alt_d;

  assign rise = pin & ~pin_q;
  assign fall = ~pin & pin_q;
  assign lim  = (mode == CM_RISE4) ? LIM_S : LIM_L;

  always_comb begin
    evt   = 1'b0;
    pre_d = pre_q;
    alt_d = alt_q;
    if (run) begin
      unique case (mode)
        CM_ANY:  evt = rise | fall;
        CM_FALL: evt = fall;
        CM_RISE: evt = rise;
        CM_RISE4, CM_RISE16: begin
          if (rise) begin
            if (pre_q == lim) begin
              evt   = 1'b1;
              pre_d = '0;
            end else begin
              pre_d = pre_q + 1'b1;
            end
          end
        end
        CM_ALT: begin
          if (alt_q ? rise : fall) begin
            evt   = 1'b1;
            alt_d = ~alt_q;
          end
        end
        default: evt = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      pre_q <= '0;
      alt_q <= 1'b0;
    end else begin
      pin_q <= pin;
      if (clr) begin
        pre_q <= '0;
        alt_q <= alt_init;
      end else begin
        pre_q <= pre_d;
        alt_q <= alt_d;
      end
    end
  end

endmodule

// File: rtl/tcap_fifo.sv
module tcap_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   CAP  = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == CAP);
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/tcap_irq.sv
module tcap_irq #(
  parameter int unsigned RW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [RW-1:0] rate,
  output logic          irq
);
  logic [RW-1:0] cnt;
  logic          hit;

  assign hit = push & (cnt == rate);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      irq <= hit;
      if (hit)       cnt <= '0;
      else if (push) cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
  import tcap_pkg::*;
#(
  parameter int unsigned TW    = 16,
  parameter int unsigned DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  input  logic            dbg_mode,
  input  logic            cpu_idle,
  input  logic [TW-1:0]   tmr_a,
  input  logic [TW-1:0]   tmr_b,
  input  logic            cap_pin,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [2*TW-1:0] rd_data,
  output logic            irq
);
  localparam int unsigned CAPW = 2 * TW;

  cap_cfg_t        cfg_q;
  logic            ovf_q;
  logic            halt, run, clr, alt_init;
  logic            evt, push, pop, full, empty;
  logic [CAPW-1:0] cap_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q.en    <= cfg_wdata[POS_EN];
      cfg_q.sidl  <= cfg_wdata[POS_SIDL];
      cfg_q.fedge <= cfg_wdata[POS_FEDGE];
      cfg_q.wide  <= cfg_wdata[POS_WIDE];
      cfg_q.sel_a <= cfg_wdata[POS_SEL];
      cfg_q.irate <= cfg_wdata[POS_RATE+1:POS_RATE];
      cfg_q.mode  <= cap_mode_e'(cfg_wdata[2:0]);
      if (dbg_mode) cfg_q.frz <= cfg_wdata[POS_FRZ];
    end
  end

  assign halt     = (cfg_q.frz & dbg_mode) | (cfg_q.sidl & cpu_idle);
  assign run      = cfg_q.en & ~halt & ~cfg_we;
  assign clr      = cfg_we | ~cfg_q.en;
  assign alt_init = cfg_we ? cfg_wdata[POS_FEDGE] : cfg_q.fedge;

  tcap_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .run      (run),
    .alt_init (alt_init),
    .pin      (cap_pin),
    .mode     (cfg_q.mode),
    .evt      (evt)
  );

  assign cap_val = cfg_q.wide  ? {tmr_b, tmr_a} :
                   cfg_q.sel_a ? {{TW{1'b0}}, tmr_a} : {{TW{1'b0}}, tmr_b};

  assign rd_valid = ~empty;
  assign pop      = rd_valid & rd_ready;
  assign push     = evt & (~full | pop);

  tcap_fifo #(.W(CAPW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (~cfg_q.en),
    .push  (push),
    .pop   (pop),
    .din   (cap_val),
    .dout  (rd_data),
    .empty (empty),
    .full  (full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !cfg_q.en)   ovf_q <= 1'b0;
    else if (pop)              ovf_q <= 1'b0;
    else if (evt && full)      ovf_q <= 1'b1;
  end

  tcap_irq #(.RW(2)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .push  (push),
    .rate  (cfg_q.irate),
    .irq   (irq)
  );

  always_comb begin
    cfg_rdata                            = '0;
    cfg_rdata[POS_EN]                    = cfg_q.en;
    cfg_rdata[POS_FRZ]                   = cfg_q.frz & dbg_mode;
    cfg_rdata[POS_SIDL]                  = cfg_q.sidl;
    cfg_rdata[POS_FEDGE]                 = cfg_q.fedge;
    cfg_rdata[POS_WIDE]                  = cfg_q.wide;
    cfg_rdata[POS_SEL]                   = cfg_q.sel_a;
    cfg_rdata[POS_RATE+1:POS_RATE]       = cfg_q.irate;
    cfg_rdata[POS_OVF]                   = ovf_q;
    cfg_rdata[POS_NE]                    = ~empty;
    cfg_rdata[2:0]                       = cfg_q.mode;
  end

endmodule

// File: rtl/tcap_chk.sv
module tcap_chk #(
  parameter int unsigned CAPW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic            en_rd,
  input logic            frz_rd,
  input logic            sidl_rd,
  input logic            ovf_rd,
  input logic            cpu_idle,
  input logic            rd_valid,
  input logic            rd_ready,
  input logic [CAPW-1:0] rd_data,
  input logic            irq
);

  // R2
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en_rd) |-> (!rd_valid && !irq));

  // R3
  frz_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_rd && en_rd) |=> !irq);

  // R4
  idle_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sidl_rd && cpu_idle) |=> !irq);

  // R9
  irq_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rd_valid);

  // R10
  ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_rd) |-> rd_valid);

  // R10
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> !ovf_rd);

  // R11
  wr_noirq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !irq);

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && en_rd) |=> (rd_valid && $stable(rd_data)));

endmodule

bind tcap_unit tcap_chk #(.CAPW(CAPW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_we   (cfg_we),
  .en_rd    (cfg_rdata[15]),
  .frz_rd   (cfg_rdata[14]),
  .sidl_rd  (cfg_rdata[13]),
  .ovf_rd   (cfg_rdata[4]),
  .cpu_idle (cpu_idle),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_data  (rd_data),
  .irq      (irq)
);

// File: tb/tcap_unit_tb.sv
module tcap_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        dbg_mode = 1'b0;
  logic        cpu_idle = 1'b0;
  logic [15:0] tmr_a = 16'h0100;
  logic [15:0] tmr_b = 16'h9000;
  logic        cap_pin = 1'b0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [31:0] rd_data;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  int irq_seen = 0;
  bit tmr_run = 1'b1;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tcap_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .dbg_mode(dbg_mode), .cpu_idle(cpu_idle),
    .tmr_a(tmr_a), .tmr_b(tmr_b), .cap_pin(cap_pin), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  bit m_en, m_frz, m_sidl, m_fedge, m_wide, m_sel, m_ovf, m_irq, m_prev, m_alt;
  int m_irate, m_mode, m_pc, m_ic;
  logic [31:0] q[$];
  bit rise, fall, pop, halt, ev, full;

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_en, m_frz, m_sidl, m_fedge, m_wide, m_sel, m_ovf, m_irq, m_prev, m_alt} = '0;
      m_irate = 0; m_mode = 0; m_pc = 0; m_ic = 0;
      q.delete();
    end else begin
      rise = cap_pin && !m_prev;
      fall = !cap_pin && m_prev;
      pop  = (q.size() > 0) && rd_ready;
      halt = (m_frz && dbg_mode) || (m_sidl && cpu_idle);
      ev = 1'b0;
      m_irq = 1'b0;
      if (m_en && !halt && !cfg_we) begin
        case (m_mode)
          1: ev = rise || fall;
          2: ev = fall;
          3: ev = rise;
          4, 5: if (rise) begin
            m_pc++;
            if (m_pc == ((m_mode == 4) ? 4 : 16)) begin ev = 1'b1; m_pc = 0; end
          end
          6: if (m_alt ? rise : fall) begin ev = 1'b1; m_alt = !m_alt; end
          default: ev = 1'b0;
        endcase
      end
      if (!m_en) begin
        q.delete();
        m_ovf = 1'b0;
      end else begin
        full = (q.size() >= 4);
        if (pop) begin void'(q.pop_front()); m_ovf = 1'b0; end
        if (ev) begin
          if (!full || pop) begin
            q.push_back(m_wide ? {tmr_b, tmr_a} : {16'h0, (m_sel ? tmr_a : tmr_b)});
            if (m_ic == m_irate) begin m_irq = 1'b1; m_ic = 0; end else m_ic++;
          end else begin
            m_ovf = 1'b1;
          end
        end
      end
      if (cfg_we || !m_en) begin
        m_pc = 0; m_ic = 0;
        m_alt = cfg_we ? cfg_wdata[9] : m_fedge;
      end
      if (cfg_we) begin
        m_en = cfg_wdata[15]; m_sidl = cfg_wdata[13]; m_fedge = cfg_wdata[9];
        m_wide = cfg_wdata[8]; m_sel = cfg_wdata[7]; m_irate = int'(cfg_wdata[6:5]);
        m_mode = int'(cfg_wdata[2:0]);
        if (dbg_mode) m_frz = cfg_wdata[14];
      end
      m_prev = cap_pin;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cfg_rdata[31:16] == 16'h0 && cfg_rdata[12:10] == 3'b0, "R1 reserved", cfg_rdata, 32'h0);
      chk({cfg_rdata[15], cfg_rdata[13], cfg_rdata[9:5], cfg_rdata[2:0]} ==
          {m_en, m_sidl, m_fedge, m_wide, m_sel, m_irate[1:0], m_mode[2:0]},
          "R1 fields", cfg_rdata, 32'h0);
      chk(cfg_rdata[14] == (m_frz && dbg_mode), "R3 freeze read", {31'h0, cfg_rdata[14]}, {31'h0, m_frz && dbg_mode});
      chk(cfg_rdata[4] == m_ovf, "R10 overflow", {31'h0, cfg_rdata[4]}, {31'h0, m_ovf});
      chk(cfg_rdata[3] == (q.size() > 0), "R10 not-empty", {31'h0, cfg_rdata[3]}, q.size());
      chk(rd_valid == (q.size() > 0), "R10 rd_valid", {31'h0, rd_valid}, q.size());
      if (rd_valid && q.size() > 0) chk(rd_data == q[0], "R8 rd_data", rd_data, q[0]);
      chk(irq == m_irq, "R9 irq", {31'h0, irq}, {31'h0, m_irq});
      if (irq) irq_seen++;
    end
  end

  always @(negedge clk) begin
    #2;
    if (tmr_run) begin
      tmr_a <= tmr_a + 16'd1;
      tmr_b <= tmr_b + 16'd3;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #3;
  endtask

  function automatic logic [31:0] cfgv(input bit en, input bit frz, input bit sidl, input bit fe,
                                       input bit wide, input bit sel, input int rate, input int mode);
    logic [31:0] v = '0;
    v[15] = en; v[14] = frz; v[13] = sidl; v[9] = fe; v[8] = wide; v[7] = sel;
    v[6:5] = rate[1:0]; v[2:0] = mode[2:0];
    return v;
  endfunction

  task automatic wr(input logic [31:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      cap_pin = 1'b1; tick(2);
      cap_pin = 1'b0; tick(2);
    end
  endtask

  task automatic drain(output int n);
    n = 0;
    rd_ready = 1'b1;
    while (rd_valid) begin n++; tick(1); end
    rd_ready = 1'b0;
    tick(1);
  endtask

  task automatic expect_n(input string tag, input int exp);
    int got;
    drain(got);
    chk(got == exp, tag, got, exp);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] held;
    tick(4);
    rst_n = 1'b1;
    tick(1);
    chk(cfg_rdata == 32'h0 && !rd_valid && !irq, "R2 reset state", cfg_rdata, 32'h0);

    // R1 reserved bits ignored
    wr(32'hFFFF_1C00 | cfgv(1, 0, 0, 0, 0, 1, 0, 3));
    chk(cfg_rdata == 32'h0000_8083, "R1 readback", cfg_rdata, 32'h0000_8083);

    // R5 edge modes
    pulses(3); expect_n("R5 rising count", 3);
    wr(cfgv(1, 0, 0, 0, 0, 1, 0, 2)); pulses(3); expect_n("R5 falling count", 3);
    wr(cfgv(1, 0, 0, 0, 0, 1, 0, 1)); pulses(2); expect_n("R5 any-edge count", 4);
    wr(cfgv(1, 0, 0, 0, 0, 1, 0, 7)); pulses(2); expect_n("R5 reserved mode count", 0);

    // R10 overflow
    wr(cfgv(1, 0, 0, 0, 0, 1, 0, 2)); pulses(5);
    chk(cfg_rdata[4] == 1'b1, "R10 overflow set", cfg_rdata, 32'h10);
    expect_n("R10 depth", 4);
    chk(cfg_rdata[4] == 1'b0 && cfg_rdata[3] == 1'b0, "R10 flags after drain", cfg_rdata, 32'h0);

    // R6 prescaled rising
    wr(cfgv(1, 0, 0, 0, 0, 1, 0, 4)); pulses(9); expect_n("R6 every 4th", 2);
    wr(cfgv(1, 0, 0, 0, 0, 1, 0, 5)); pulses(17); expect_n("R6 every 16th", 1);

    // R7 alternating
    wr(cfgv(1, 0, 0, 0, 0, 1, 0, 6)); pulses(2); expect_n("R7 falling first", 3);
    wr(cfgv(1, 0, 0, 1, 0, 1, 0, 6)); pulses(2); expect_n("R7 rising first", 4);

    // R9 interrupt rate
    rd_ready = 1'b1;
    wr(cfgv(1, 0, 0, 0, 0, 1, 2, 1)); irq_seen = 0; pulses(3); tick(2);
    chk(irq_seen == 2, "R9 every third", irq_seen, 2);
    wr(cfgv(1, 0, 0, 0, 0, 1, 3, 1)); irq_seen = 0; pulses(4); tick(2);
    chk(irq_seen == 2, "R9 every fourth", irq_seen, 2);
    wr(cfgv(1, 0, 0, 0, 0, 1, 0, 1)); irq_seen = 0; pulses(2); tick(2);
    chk(irq_seen == 4, "R9 every capture", irq_seen, 4);
    rd_ready = 1'b0;

    // R3 freeze
    wr(cfgv(1, 1, 0, 0, 0, 1, 0, 3));
    dbg_mode = 1'b1; tick(1);
    chk(cfg_rdata[14] == 1'b0, "R3 write outside debug ignored", cfg_rdata, 32'h0);
    wr(cfgv(1, 1, 0, 0, 0, 1, 0, 3));
    chk(cfg_rdata[14] == 1'b1, "R3 write in debug", cfg_rdata, 32'h4000);
    pulses(2); expect_n("R3 frozen capture", 0);
    dbg_mode = 1'b0; tick(1);
    chk(cfg_rdata[14] == 1'b0, "R3 reads zero outside debug", cfg_rdata, 32'h0);
    pulses(2); expect_n("R3 runs outside debug", 2);
    dbg_mode = 1'b1; wr(cfgv(1, 0, 0, 0, 0, 1, 0, 3)); dbg_mode = 1'b0;

    // R4 idle stop
    wr(cfgv(1, 0, 1, 0, 0, 1, 0, 3)); cpu_idle = 1'b1;
    pulses(2); expect_n("R4 halted in idle", 0);
    cpu_idle = 1'b0; pulses(2); expect_n("R4 runs when not idle", 2);
    wr(cfgv(1, 0, 0, 0, 0, 1, 0, 3)); cpu_idle = 1'b1;
    pulses(2); expect_n("R4 idle ignored", 2);
    cpu_idle = 1'b0;

    // R8 timer selection with fixed timer values
    tmr_run = 1'b0; tick(1);
    tmr_a = 16'h1234; tmr_b = 16'hABCD;
    wr(cfgv(1, 0, 0, 0, 1, 1, 0, 3)); pulses(1);
    chk(rd_data == 32'hABCD_1234, "R8 wide", rd_data, 32'hABCD_1234); expect_n("R8 wide count", 1);
    wr(cfgv(1, 0, 0, 0, 1, 0, 0, 3)); pulses(1);
    chk(rd_data == 32'hABCD_1234, "R8 select ignored when wide", rd_data, 32'hABCD_1234); expect_n("R8 count", 1);
    wr(cfgv(1, 0, 0, 0, 0, 1, 0, 3)); pulses(1);
    chk(rd_data == 32'h0000_1234, "R8 timer A", rd_data, 32'h0000_1234); expect_n("R8 count", 1);
    wr(cfgv(1, 0, 0, 0, 0, 0, 0, 3)); pulses(1);
    chk(rd_data == 32'h0000_ABCD, "R8 timer B", rd_data, 32'h0000_ABCD); expect_n("R8 count", 1);
    tmr_run = 1'b1;

    // R11 write clears prescale, blocks same-cycle capture
    wr(cfgv(1, 0, 0, 0, 0, 1, 0, 4)); pulses(2);
    wr(cfgv(1, 0, 0, 0, 0, 1, 0, 4)); pulses(2); expect_n("R11 prescale restart", 0);
    pulses(2); expect_n("R11 fourth rise after write", 1);
    wr(cfgv(1, 0, 0, 0, 0, 1, 0, 3));
    cap_pin = 1'b1; cfg_we = 1'b1; cfg_wdata = cfgv(1, 0, 0, 0, 0, 1, 0, 3); tick(1);
    cfg_we = 1'b0; tick(1); cap_pin = 1'b0; tick(2);
    expect_n("R11 capture blocked by write", 0);

    // R12 hold under back-pressure
    pulses(2);
    held = rd_data; tick(3);
    chk(rd_valid && rd_data == held, "R12 held data", rd_data, held);
    expect_n("R12 count", 2);

    // R2 disable flushes
    pulses(3);
    wr(cfgv(0, 0, 0, 0, 0, 1, 0, 3)); tick(1);
    chk(!rd_valid && cfg_rdata[4:3] == 2'b00, "R2 flushed", cfg_rdata, 32'h0);
    pulses(2);
    chk(!rd_valid && !irq, "R2 no capture when off", {31'h0, rd_valid}, 32'h0);
    wr(cfgv(1, 0, 0, 0, 0, 1, 0, 3)); expect_n("R2 empty after enable", 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule